// File: doc/BRIEF.md
# Interrupt Distributor Register Front-End

This block is the memory-mapped register front-end of an interrupt distributor. A requester presents one access per cycle. Each access carries an offset, a size code for 1, 2, 4 or 8 bytes, write data, a write flag and a secure attribute. The front-end decodes the offset into a register window and decides whether the access is legal for that window and size. Legal writes go to the per-interrupt state: the enable, pending and active bitmaps (each with a set view and a clear view), the group bitmap and the byte-wide priority array.

An illegal access never faults the bus. It completes like any other access, with zero read data and no state change, and it raises a one-cycle error flag. The requester uses that flag to log the misuse. Interrupt IDs below 32 are reserved for private interrupts, and IDs at or above the implemented count do not exist. Both ranges read as zero and ignore writes. The group bitmap is further hidden from non-secure accesses while the disable-security control bit is clear.

Read data is right-aligned in `rsp_rdata` and write data is taken from the low bits of `req_wdata`. Every access produces a registered response one cycle later.

Top module: `dist_regfront`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high in the next cycle, and no other cycle does. `rsp_err` is high only together with `rsp_valid`, so it is a one-cycle pulse per flagged access.
- R2: Size code 1 (2 bytes) is illegal at every offset. It sets `rsp_err`, returns zero and changes no state.
- R3: Size code 0 (1 byte) is legal only in the priority window 0x400–0x7FF and in the legacy window 0x800–0xBFF. The legacy window reads zero and ignores writes. A byte access anywhere else is flagged and changes nothing.
- R4: Size code 3 (8 bytes) is legal only in the routing window 0x6000–0x7FFF at an 8-aligned offset, where it reads zero and writes nothing here. An 8-byte access anywhere else is flagged.
- R5: A 4-byte access (size code 2) is flagged if its offset is not 4-aligned or lies in no window. A flagged access returns zero and has no effect.
- R6: Word n of the set-enable window (0x100+4n) and of the clear-enable window (0x180+4n) covers IDs 32n..32n+31, with bit i standing for ID 32n+i. A set write ORs in its 1-bits and a clear write removes them. A read of either view returns the bitmap. Pending (0x200/0x280) and active (0x300/0x380) behave the same way.
- R7: In every bitmap, IDs below 32 and IDs at or above `NUM_IRQ` read as zero and ignore writes, with no error.
- R8: The group bitmap (0x080+4n, same bit layout as R6) is written directly. It reads zero and ignores writes when the access is non-secure and control bit 0 is clear.
- R9: Control register 0x000 holds the disable-security flag in bit 0. Other bits read zero. Only secure writes change it.
- R10: A 4-byte write at 0x400+id sets the priorities of IDs id..id+3 from bytes 0..3 of the data, lowest byte first. It is ignored entirely if any of the four IDs is below 32 or at or above `NUM_IRQ`. Byte accesses address one ID. Reads return the stored priorities, with zero in lanes for invalid IDs.
- R11: The info register 0x004 reads `NUM_IRQ`. A write to it is ignored and flagged. The trigger register 0x00C accepts writes without a flag, but a read of it returns zero and is flagged.
- R12: The status register 0x008 always reads zero, ignores writes and is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| req_offset | input | 16 | Byte offset in the register space |
| req_secure | input | 1 | Access carries the secure attribute |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data (zero for writes and flagged accesses) |
| rsp_err | output | 1 | Access was illegal or misused |

## Verification
Every result of this block is due in the cycle after the edge that accepts the request. That edge also commits any write, so an access issued in the following cycle already sees the new state. The bench drives each request at a falling edge and reads `rsp_rdata`/`rsp_err` at the next falling edge, exactly one register stage later. Effects of ignored or flagged writes are checked by a separate read access afterwards. The one-cycle width of the error pulse is checked by sampling one idle cycle after a flagged access.

// File: rtl/dist_pkg.sv
package dist_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_INFO, K_STAT, K_TRIG, K_GROUP,
    K_EN_SET, K_EN_CLR, K_PD_SET, K_PD_CLR, K_AC_SET, K_AC_CLR,
    K_PRIO, K_LEGACY, K_ROUTE
  } reg_kind_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } bm_op_e;

  localparam int OFF_W      = 16;
  localparam int FIRST_SHARED = 32;

endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic             write,
  output reg_kind_e        kind,
  output logic             legal,
  output logic             err
);

  always_comb begin
    kind = K_NONE;
    if (offset[15:4] == 12'd0) begin
      unique case (offset[3:2])
        2'd0: kind = K_CTRL;
        2'd1: kind = K_INFO;
        2'd2: kind = K_STAT;
        default: kind = K_TRIG;
      endcase
    end else if (offset[15:10] == 6'd0) begin
      unique case (offset[9:7])
        3'd1: kind = K_GROUP;
        3'd2: kind = K_EN_SET;
        3'd3: kind = K_EN_CLR;
        3'd4: kind = K_PD_SET;
        3'd5: kind = K_PD_CLR;
        3'd6: kind = K_AC_SET;
        3'd7: kind = K_AC_CLR;
        default: kind = K_NONE;
      endcase
    end else if (offset[15:10] == 6'd1) begin
      kind = K_PRIO;
    end else if (offset[15:10] == 6'd2) begin
      kind = K_LEGACY;
    end else if (offset[15:13] == 3'd3) begin
      kind = K_ROUTE;
    end
  end

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE:  legal = (kind == K_PRIO) || (kind == K_LEGACY);
      SZ_HALF:  legal = 1'b0;
      SZ_WORD:  legal = (kind != K_NONE) && (offset[1:0] == 2'b00);
      default:  legal = (kind == K_ROUTE) && (offset[2:0] == 3'b000);
    endcase
    err = !legal || (!write && kind == K_TRIG) || (write && kind == K_INFO);
  end

endmodule

// File: rtl/dist_bitmap.sv
module dist_bitmap
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  bm_op_e      wr_op,
  input  logic [4:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam int NWORDS = NUM_IRQ / 32;

  logic [31:0] word_q [1:NWORDS-1];
  logic [31:0] word_d [1:NWORDS-1];

  always_comb begin
    for (int w = 1; w < NWORDS; w++) begin
      word_d[w] = word_q[w];
      if (wr_en && idx == 5'(w)) begin
        unique case (wr_op)
          OP_LOAD: word_d[w] = wdata;
          OP_SET:  word_d[w] = word_q[w] | wdata;
          OP_CLR:  word_d[w] = word_q[w] & ~wdata;
          default: word_d[w] = word_q[w];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 1; w < NWORDS; w++) word_q[w] <= '0;
    end else if (wr_en) begin
      for (int w = 1; w < NWORDS; w++) word_q[w] <= word_d[w];
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 1; w < NWORDS; w++) begin
      if (idx == 5'(w)) rdata = word_q[w];
    end
  end

endmodule

// File: rtl/dist_prio.sv
module dist_prio
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        word,
  input  logic [9:0]  id,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  logic [PRIO_W-1:0] prio_q [FIRST_SHARED:NUM_IRQ-1];
  logic [PRIO_W-1:0] prio_d [FIRST_SHARED:NUM_IRQ-1];
  logic              quad_ok;

  assign quad_ok = (int'(id) >= FIRST_SHARED) && (int'(id) + 3 < NUM_IRQ);

  always_comb begin
    for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
      prio_d[i] = prio_q[i];
      if (word) begin
        if (quad_ok && (i >> 2) == int'(id[9:2]))
          prio_d[i] = wdata[8*(i%4) +: PRIO_W];
      end else if (int'(id) == i) begin
        prio_d[i] = wdata[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = FIRST_SHARED; i < NUM_IRQ; i++) prio_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = FIRST_SHARED; i < NUM_IRQ; i++) prio_q[i] <= prio_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
      for (int k = 0; k < 4; k++) begin
        if ((k == 0 || word) && int'(id) + k == i)
          rdata[8*k +: PRIO_W] = prio_q[i];
      end
    end
  end

endmodule

// File: rtl/dist_regfront.sv
module dist_regfront
  import dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [15:0] req_offset,
  input  logic        req_secure,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_err
);

  reg_kind_e   kind;
  logic        legal, dec_err, do_wr, grp_ok;
  logic        dis_sec_q, dis_sec_d;
  logic [31:0] bm_rd [3];
  logic [31:0] grp_rd, prio_rd, rd_c;
  logic [63:0] rdata_d;
  logic        unused_hi;

  assign unused_hi = ^req_wdata[63:32];

  dist_decode u_dec (
    .offset (req_offset),
    .size   (req_size),
    .write  (req_write),
    .kind   (kind),
    .legal  (legal),
    .err    (dec_err)
  );

  assign do_wr  = req_valid && req_write && legal;
  assign grp_ok = req_secure || dis_sec_q;

  // control register: secure writes only
  always_comb begin
    dis_sec_d = dis_sec_q;
    if (do_wr && kind == K_CTRL && req_secure) dis_sec_d = req_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_sec_q <= 1'b0;
    else        dis_sec_q <= dis_sec_d;
  end

  // enable / pending / active bitmaps, each with set and clear views
  for (genvar b = 0; b < 3; b++) begin : g_bm
    localparam reg_kind_e SET_K = (b == 0) ? K_EN_SET : ((b == 1) ? K_PD_SET : K_AC_SET);
    localparam reg_kind_e CLR_K = (b == 0) ? K_EN_CLR : ((b == 1) ? K_PD_CLR : K_AC_CLR);
    dist_bitmap #(.NUM_IRQ(NUM_IRQ)) u_bm (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (do_wr && (kind == SET_K || kind == CLR_K)),
      .wr_op ((kind == CLR_K) ? OP_CLR : OP_SET),
      .idx   (req_offset[6:2]),
      .wdata (req_wdata[31:0]),
      .rdata (bm_rd[b])
    );
  end

  dist_bitmap #(.NUM_IRQ(NUM_IRQ)) u_grp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (do_wr && kind == K_GROUP && grp_ok),
    .wr_op (OP_LOAD),
    .idx   (req_offset[6:2]),
    .wdata (req_wdata[31:0]),
    .rdata (grp_rd)
  );

  dist_prio #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (do_wr && kind == K_PRIO),
    .word  (acc_size_e'(req_size) == SZ_WORD),
    .id    (req_offset[9:0]),
    .wdata (req_wdata[31:0]),
    .rdata (prio_rd)
  );

  always_comb begin
    unique case (kind)
      K_CTRL:             rd_c = {31'd0, dis_sec_q};
      K_INFO:             rd_c = 32'(NUM_IRQ);
      K_GROUP:            rd_c = grp_ok ? grp_rd : 32'd0;
      K_EN_SET, K_EN_CLR: rd_c = bm_rd[0];
      K_PD_SET, K_PD_CLR: rd_c = bm_rd[1];
      K_AC_SET, K_AC_CLR: rd_c = bm_rd[2];
      K_PRIO:             rd_c = prio_rd;
      default:            rd_c = 32'd0;
    endcase
    if (dec_err || req_write) rd_c = 32'd0;
    rdata_d = req_valid ? {32'd0, rd_c} : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      if (req_valid) rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/dist_regfront_chk.sv
module dist_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [15:0] req_offset,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        rsp_err
);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r1_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  a_r2_half_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd1) |=> rsp_err);

  a_r3_byte_low_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0 && req_offset[15:10] == 6'd0) |=> rsp_err);

  a_r4_dword_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3 && req_offset[15:13] != 3'd3) |=> rsp_err);

  a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 64'd0));

  a_r12_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd2 && req_offset == 16'h0008)
      |=> (!rsp_err && rsp_rdata == 64'd0));

endmodule

bind dist_regfront dist_regfront_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_offset (req_offset),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err)
);

// File: tb/sim_dist_regfront.sv
module sim_dist_regfront;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_secure;
  logic [1:0]  req_size;
  logic [15:0] req_offset;
  logic [63:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit timed_out = 0;

  always #5 clk = ~clk;

  dist_regfront #(.NUM_IRQ(64), .PRIO_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .req_secure(req_secure),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // request driven at a falling edge, response sampled one falling edge later
  task automatic acc(input logic wr, input logic [1:0] sz, input logic [15:0] off,
                     input logic sec, input logic [63:0] wd,
                     output logic [63:0] rd, output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_offset = off; req_secure = sec; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdc(input string tag, input logic [1:0] sz, input logic [15:0] off,
                     input logic sec, input logic [63:0] exp, input logic exp_err);
    logic [63:0] rd; logic er, vl;
    acc(1'b0, sz, off, sec, 64'd0, rd, er, vl);
    chk({tag, " data"}, rd, exp);
    chk({tag, " err"}, {63'd0, er}, {63'd0, exp_err});
  endtask

  task automatic wrc(input string tag, input logic [1:0] sz, input logic [15:0] off,
                     input logic sec, input logic [63:0] wd, input logic exp_err);
    logic [63:0] rd; logic er, vl;
    acc(1'b1, sz, off, sec, wd, rd, er, vl);
    chk({tag, " err"}, {63'd0, er}, {63'd0, exp_err});
  endtask

  task automatic t_reset;
    logic [63:0] rd; logic er, vl;
    chk("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 reset rsp_err", {63'd0, rsp_err}, 64'd0);
    acc(1'b0, 2'd2, 16'h0000, 1'b1, 64'd0, rd, er, vl);
    chk("R1 valid one cycle later", {63'd0, vl}, 64'd1);
    chk("R9 reset ctrl", rd, 64'd0);
    @(negedge clk);
    chk("R1 valid drops when idle", {63'd0, rsp_valid}, 64'd0);
    rdc("R6 reset enable", 2'd2, 16'h0104, 1'b1, 64'd0, 1'b0);
  endtask

  task automatic t_setclr;
    wrc("R6 set-enable write", 2'd2, 16'h0104, 1'b0, 64'h0000_F00F, 1'b0);
    rdc("R6 set view", 2'd2, 16'h0104, 1'b0, 64'h0000_F00F, 1'b0);
    rdc("R6 clear view", 2'd2, 16'h0184, 1'b0, 64'h0000_F00F, 1'b0);
    wrc("R6 clear-enable write", 2'd2, 16'h0184, 1'b0, 64'h0000_000F, 1'b0);
    rdc("R6 enable after clear", 2'd2, 16'h0104, 1'b0, 64'h0000_F000, 1'b0);
    wrc("R6 set-pend", 2'd2, 16'h0204, 1'b1, 64'h0000_00A5, 1'b0);
    rdc("R6 pend via clear view", 2'd2, 16'h0284, 1'b1, 64'h0000_00A5, 1'b0);
    rdc("R6 pend not in enable", 2'd2, 16'h0104, 1'b1, 64'h0000_F000, 1'b0);
    wrc("R6 set-active", 2'd2, 16'h0304, 1'b1, 64'h0000_0003, 1'b0);
    wrc("R6 clear-active", 2'd2, 16'h0384, 1'b1, 64'h0000_0001, 1'b0);
    rdc("R6 active result", 2'd2, 16'h0304, 1'b1, 64'h0000_0002, 1'b0);
  endtask

  task automatic t_range;
    wrc("R7 low IDs write", 2'd2, 16'h0100, 1'b1, 64'hFFFF_FFFF, 1'b0);
    rdc("R7 low IDs read zero", 2'd2, 16'h0100, 1'b1, 64'd0, 1'b0);
    wrc("R7 high IDs write", 2'd2, 16'h0108, 1'b1, 64'hFFFF_FFFF, 1'b0);
    rdc("R7 high IDs read zero", 2'd2, 16'h0108, 1'b1, 64'd0, 1'b0);
    rdc("R7 existing word intact", 2'd2, 16'h0104, 1'b1, 64'h0000_F000, 1'b0);
  endtask

  task automatic t_group;
    wrc("R8 nonsecure group write", 2'd2, 16'h0084, 1'b0, 64'h0000_1234, 1'b0);
    rdc("R8 nonsecure write ignored", 2'd2, 16'h0084, 1'b1, 64'd0, 1'b0);
    wrc("R8 secure group write", 2'd2, 16'h0084, 1'b1, 64'h0000_1234, 1'b0);
    rdc("R8 secure read", 2'd2, 16'h0084, 1'b1, 64'h0000_1234, 1'b0);
    rdc("R8 nonsecure read hidden", 2'd2, 16'h0084, 1'b0, 64'd0, 1'b0);
    wrc("R9 nonsecure ctrl write", 2'd2, 16'h0000, 1'b0, 64'hFFFF_FFFF, 1'b0);
    rdc("R9 ctrl unchanged", 2'd2, 16'h0000, 1'b1, 64'd0, 1'b0);
    wrc("R9 secure ctrl write", 2'd2, 16'h0000, 1'b1, 64'hFFFF_FFFF, 1'b0);
    rdc("R9 ctrl only bit0", 2'd2, 16'h0000, 1'b0, 64'd1, 1'b0);
    rdc("R8 nonsecure read open", 2'd2, 16'h0084, 1'b0, 64'h0000_1234, 1'b0);
    wrc("R8 nonsecure write open", 2'd2, 16'h0084, 1'b0, 64'h0000_0055, 1'b0);
    rdc("R8 direct replace", 2'd2, 16'h0084, 1'b1, 64'h0000_0055, 1'b0);
  endtask

  task automatic t_prio;
    wrc("R10 word write 32..35", 2'd2, 16'h0420, 1'b0, 64'h4433_2211, 1'b0);
    rdc("R10 byte lane 0", 2'd0, 16'h0420, 1'b0, 64'h11, 1'b0);
    rdc("R10 byte lane 3", 2'd0, 16'h0423, 1'b0, 64'h44, 1'b0);
    wrc("R10 byte write", 2'd0, 16'h0421, 1'b0, 64'hAA, 1'b0);
    rdc("R10 word read", 2'd2, 16'h0420, 1'b0, 64'h4433_AA11, 1'b0);
    wrc("R10 word low range", 2'd2, 16'h041C, 1'b0, 64'hFFFF_FFFF, 1'b0);
    rdc("R10 low range ignored", 2'd2, 16'h041C, 1'b0, 64'd0, 1'b0);
    wrc("R10 word top", 2'd2, 16'h043C, 1'b0, 64'h0D0C_0B0A, 1'b0);
    rdc("R10 word top read", 2'd2, 16'h043C, 1'b0, 64'h0D0C_0B0A, 1'b0);
    wrc("R5 misaligned word", 2'd2, 16'h043E, 1'b0, 64'hFFFF_FFFF, 1'b1);
    rdc("R5 misaligned no effect", 2'd2, 16'h043C, 1'b0, 64'h0D0C_0B0A, 1'b0);
    wrc("R10 beyond count", 2'd2, 16'h0440, 1'b0, 64'hFFFF_FFFF, 1'b0);
    rdc("R10 beyond count zero", 2'd2, 16'h0440, 1'b0, 64'd0, 1'b0);
    rdc("R10 private ID byte", 2'd0, 16'h0410, 1'b0, 64'd0, 1'b0);
  endtask

  task automatic t_sizes;
    rdc("R2 half read", 2'd1, 16'h0104, 1'b1, 64'd0, 1'b1);
    @(negedge clk);
    chk("R1 err pulse single cycle", {63'd0, rsp_err}, 64'd0);
    wrc("R2 half write", 2'd1, 16'h0104, 1'b1, 64'hFFFF, 1'b1);
    rdc("R2 half write no effect", 2'd2, 16'h0104, 1'b1, 64'h0000_F000, 1'b0);
    rdc("R3 byte on bitmap", 2'd0, 16'h0104, 1'b1, 64'd0, 1'b1);
    wrc("R3 byte write bitmap", 2'd0, 16'h0105, 1'b1, 64'hFF, 1'b1);
    rdc("R3 byte write no effect", 2'd2, 16'h0104, 1'b1, 64'h0000_F000, 1'b0);
    rdc("R3 legacy byte read", 2'd0, 16'h0803, 1'b1, 64'd0, 1'b0);
    wrc("R3 legacy byte write", 2'd0, 16'h0803, 1'b1, 64'hFF, 1'b0);
    rdc("R4 dword on bitmap", 2'd3, 16'h0100, 1'b1, 64'd0, 1'b1);
    rdc("R4 dword routing", 2'd3, 16'h6008, 1'b1, 64'd0, 1'b0);
    wrc("R4 dword routing write", 2'd3, 16'h6010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    rdc("R4 dword misaligned", 2'd3, 16'h6004, 1'b1, 64'd0, 1'b1);
    rdc("R5 word unmapped", 2'd2, 16'h5000, 1'b1, 64'd0, 1'b1);
    rdc("R5 word in gap", 2'd2, 16'h0040, 1'b1, 64'd0, 1'b1);
  endtask

  task automatic t_special;
    rdc("R11 info read", 2'd2, 16'h0004, 1'b1, 64'd64, 1'b0);
    wrc("R11 info write flagged", 2'd2, 16'h0004, 1'b1, 64'h0, 1'b1);
    rdc("R11 info unchanged", 2'd2, 16'h0004, 1'b1, 64'd64, 1'b0);
    wrc("R11 trigger write", 2'd2, 16'h000C, 1'b1, 64'h1234, 1'b0);
    rdc("R11 trigger read flagged", 2'd2, 16'h000C, 1'b1, 64'd0, 1'b1);
    wrc("R12 status write", 2'd2, 16'h0008, 1'b1, 64'hFFFF_FFFF, 1'b0);
    rdc("R12 status reads zero", 2'd2, 16'h0008, 1'b0, 64'd0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_offset = '0; req_secure = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_setclr();
        t_range();
        t_group();
        t_prio();
        t_sizes();
        t_special();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule